// File: doc/BRIEF.md
# Ordered Store Buffer with Forwarding and Fences

This block sits between an in-order stream of memory requests from one core and a single-ported memory. Each store is placed in an eight-entry queue and written to memory later. A load that finds no queued store to its word address goes to memory ahead of older queued stores, so reads may overtake writes. A load that matches one or more queued stores is answered from the queue with the newest matching data. The memory never sees that load.

Three further request kinds control ordering on the memory side:

- A full fence holds back every later request until the queue has drained.
- An acquire load holds back every later request until its own data has returned.
- A release store waits behind all earlier work. While it is queued, no later load that misses the queue may reach memory.

Each response carries a flag that marks it as forwarded from the queue or read from memory.

Top module: `store_buffer`

## Requirements
- R1: Stores (op code 1) leave the queue strictly oldest first. The port carries one write (`mem_we`=1) per accepted memory handshake, with the address and data the store was given.
- R2: The queue holds 8 stores. With 8 stores queued, `req_ready` is low for a store request, and all 8 stores are later written to memory.
- R3: A load (op code 0) whose address matches no queued store is sent to memory. Loads take the port ahead of queued stores unless a fence or release is pending, so the read can reach memory before older stores. Its response has `rsp_fwd`=0 and carries the memory data.
- R4: A load whose address matches queued stores is answered one cycle after acceptance with `rsp_fwd`=1 and the data of the newest matching store. No memory access is made for it.
- R5: After a fence (op code 2) is accepted while stores are queued, `req_ready` stays low until every queued store has been written. A fence accepted with an empty queue leaves `req_ready` high in the next cycle.
- R6: While an acquire load (op code 3) that went to memory awaits its data, `req_ready` is low for every request.
- R7: A release store (op code 4) is queued like a store. While it is queued, no read is presented on the memory port, and queued stores take the port first. After it is written, a held miss load reads memory before younger stores drain. A release is not accepted while a load is outstanding.
- R8: While `mem_valid` is high and `mem_ready` is low, the port keeps `mem_valid`, `mem_we`, `mem_addr` and, for writes, `mem_wdata` unchanged in the next cycle.
- R9: While a plain load awaits memory data, further plain stores are accepted and other requests are held. Its read is not overtaken by those stores.
- R10: After reset, `req_ready` is high, and `mem_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 3 | 0 load, 1 store, 2 fence, 3 acquire load, 4 release store |
| req_addr | input | AW | Word address |
| req_data | input | DW | Store data |
| rsp_valid | output | 1 | Load response pulse |
| rsp_data | output | DW | Load data |
| rsp_fwd | output | 1 | 1 when data came from the queue |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data returning |
| mem_rdata | input | DW | Read data |

## Verification
Two events can fall in the same cycle: a drain handshake on the memory port and the acceptance of a miss load. The bench provokes this by releasing a stalled memory on the same edge that a load arrives behind four queued stores. It expects the first store to complete and then the read to be placed before the other three stores, which it judges from the order of the memory log. The same log shows a release retiring in the cycle before a held load wins the port, and shows a fence clearing in the cycle after the last queued write.

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fwd,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW:0]   DEPW = (PW+1)'(DEPTH);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_FN = 3'd2, OP_LA = 3'd3, OP_SR = 3'd4;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [DEPTH-1:0] q_rel;
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, count_n, rel_cnt;
  logic fence_wait, ld_busy, ld_acq, ld_sent, hold_st;
  logic [AW-1:0] ld_addr;

  wire is_st = (req_op == OP_ST) || (req_op == OP_SR);
  wire is_ld = (req_op == OP_LD) || (req_op == OP_LA);
  wire full  = (count == FULLC);
  wire empty = (count == '0);
  wire rel_q = (rel_cnt != '0);

  always_comb begin
    if (fence_wait)   req_ready = 1'b0;
    else if (ld_busy) req_ready = !ld_acq && req_op == OP_ST && !full && !rel_q;
    else if (is_st)   req_ready = !full;
    else              req_ready = 1'b1;
  end

  wire acc = req_valid && req_ready;

  logic          hit;
  logic [DW-1:0] hit_data;
  logic [PW:0]   slot;
  always_comb begin
    hit = 1'b0;
    hit_data = '0;
    slot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = {1'b0, rd_ptr} + (PW+1)'(i);
      if (slot >= DEPW) slot = slot - DEPW;
      if (CW'(i) < count && q_addr[slot[PW-1:0]] == req_addr) begin
        hit = 1'b1;
        hit_data = q_data[slot[PW-1:0]];
      end
    end
  end

  wire st_prio = fence_wait || rel_q;
  wire sel_ld  = ld_busy && !ld_sent && !rel_q && !hold_st && !(st_prio && !empty);
  assign mem_valid = sel_ld || !empty;
  assign mem_we    = !sel_ld;
  assign mem_addr  = sel_ld ? ld_addr : q_addr[rd_ptr];
  assign mem_wdata = q_data[rd_ptr];

  wire push  = acc && is_st;
  wire pop   = mem_valid && mem_ready && mem_we;
  wire ld_go = mem_valid && mem_ready && !mem_we;
  wire ld_in = acc && is_ld && !hit;
  assign count_n = count + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= req_addr;
      q_data[wr_ptr] <= req_data;
      q_rel[wr_ptr]  <= (req_op == OP_SR);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; count <= '0; rel_cnt <= '0;
      fence_wait <= 1'b0; ld_busy <= 1'b0; ld_acq <= 1'b0; ld_sent <= 1'b0;
      ld_addr <= '0; hold_st <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0; rsp_fwd <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count   <= count_n;
      rel_cnt <= rel_cnt + CW'(push && req_op == OP_SR) - CW'(pop && q_rel[rd_ptr]);
      fence_wait <= (fence_wait || (acc && req_op == OP_FN)) && (count_n != '0);
      hold_st <= mem_valid && mem_we && !mem_ready;
      if (ld_in) begin
        ld_busy <= 1'b1;
        ld_acq  <= (req_op == OP_LA);
        ld_addr <= req_addr;
        ld_sent <= 1'b0;
      end else begin
        if (ld_go) ld_sent <= 1'b1;
        if (mem_rvalid && ld_sent) begin
          ld_busy <= 1'b0;
          ld_sent <= 1'b0;
        end
      end
      rsp_valid <= (acc && is_ld && hit) || (mem_rvalid && ld_sent);
      rsp_fwd   <= acc && is_ld && hit;
      if (acc && is_ld && hit)     rsp_data <= hit_data;
      else if (mem_rvalid && ld_sent) rsp_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/store_buffer_checker.sv
module store_buffer_checker #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic          rsp_valid,
  input logic          rsp_fwd,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rvalid,
  input logic [CW-1:0] count,
  input logic [CW-1:0] rel_cnt,
  input logic          fence_wait,
  input logic          ld_busy,
  input logic          ld_acq
);
  assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr)
                                && (!mem_we || $stable(mem_wdata)));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(DEPTH) |-> !(req_valid && req_ready && (req_op == 3'd1 || req_op == 3'd4)));

  assert_fence_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fence_wait |-> !req_ready);

  assert_acquire_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy && ld_acq |-> !req_ready);

  assert_release_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt != '0 |-> !(mem_valid && !mem_we));

  assert_miss_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy && mem_rvalid |=> rsp_valid && !rsp_fwd);
endmodule

bind store_buffer store_buffer_checker #(
  .AW(AW), .DW(DW), .CW($clog2(DEPTH + 1)), .DEPTH(DEPTH)
) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
  .count(count), .rel_cnt(rel_cnt), .fence_wait(fence_wait), .ld_busy(ld_busy), .ld_acq(ld_acq)
);

// File: tb/test_store_buffer.sv
module test_store_buffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_fwd, mem_valid, mem_we;
  logic [15:0] rsp_data, mem_wdata;
  logic [7:0] mem_addr;
  logic stall = 1'b1;
  logic mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  wire mem_ready = !stall;

  store_buffer #(.AW(8), .DW(16), .DEPTH(8)) i_store_buffer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fwd(rsp_fwd), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [256];
  logic        log_we   [256];
  logic [7:0]  log_addr [256];
  logic [15:0] log_data [256];
  int n_log = 0;
  int rsp_cnt = 0;
  logic [15:0] last_data = '0;
  logic last_fwd = 1'b0;
  int checks = 0, fails = 0, cyc = 0;

  initial for (int a = 0; a < 256; a++) mem[a] = 16'(a * 3 + 7);

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      log_we[n_log] <= mem_we;
      log_addr[n_log] <= mem_addr;
      log_data[n_log] <= mem_we ? mem_wdata : mem[mem_addr];
      n_log <= n_log + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr];
      end
    end
    if (rsp_valid) begin
      rsp_cnt <= rsp_cnt + 1;
      last_data <= rsp_data;
      last_fwd <= rsp_fwd;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input logic [2:0] op, input logic [7:0] a, input int exp, input string req);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = 16'hdead;
    #1;
    check(req, int'(req_ready), exp);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    int base, yi, rc;
    logic [7:0] a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready", int'(req_ready), 1);
    check("R10 mem_valid", int'(mem_valid), 0);
    check("R10 rsp_valid", int'(rsp_valid), 0);

    // R4 forwarding sweep, R1 drain order, R2 capacity
    for (int n = 1; n <= 8; n++) begin
      stall = 1'b1;
      base = n_log;
      for (int i = 0; i < n; i++) send(3'd1, 8'(20 + i % 3), 16'(100 * n + i));
      for (int k = 0; k < 3 && k < n; k++) begin
        yi = k + 3 * ((n - 1 - k) / 3);
        send(3'd0, 8'(20 + k), 16'h0);
        check("R4 rsp_valid", int'(rsp_valid), 1);
        check("R4 fwd", int'(rsp_fwd), 1);
        check("R4 youngest data", int'(rsp_data), 100 * n + yi);
      end
      if (n == 8) probe(3'd1, 8'd29, 0, "R2 full blocks store");
      check("R4 no memory access", n_log, base);
      stall = 1'b0;
      idle(n + 4);
      check("R1 write count", n_log - base, n);
      for (int i = 0; i < n; i++) begin
        check("R1 order addr", int'(log_addr[base + i]), 20 + i % 3);
        check("R1 order data", int'(log_data[base + i]), 100 * n + i);
      end
    end

    // R3 miss load bypasses older stores
    stall = 1'b1;
    for (int i = 0; i < 4; i++) send(3'd1, 8'(30 + i), 16'(500 + i));
    base = n_log;
    stall = 1'b0;
    send(3'd0, 8'd50, 16'h0);
    idle(10);
    check("R3 first is write", int'(log_we[base]), 1);
    check("R3 read placed second", int'(log_we[base + 1]), 0);
    check("R3 read addr", int'(log_addr[base + 1]), 50);
    check("R3 rsp fwd", int'(last_fwd), 0);
    check("R3 rsp data", int'(last_data), 50 * 3 + 7);

    // R9 plain load outstanding
    stall = 1'b1;
    base = n_log;
    send(3'd0, 8'd60, 16'h0);
    send(3'd1, 8'd61, 16'd777);
    check("R9 store accepted behind load", n_log, base);
    probe(3'd0, 8'd62, 0, "R9 second load held");
    stall = 1'b0;
    idle(8);
    check("R9 read first", int'(log_we[base]), 0);
    check("R9 then write", int'(log_addr[base + 1]), 61);
    check("R9 rsp data", int'(last_data), 60 * 3 + 7);

    // R6 acquire load blocks everything
    stall = 1'b1;
    send(3'd3, 8'd70, 16'h0);
    for (int i = 0; i < 3; i++) probe(3'd1, 8'd71, 0, "R6 store held");
    probe(3'd0, 8'd72, 0, "R6 load held");
    rc = rsp_cnt;
    stall = 1'b0;
    send(3'd1, 8'd71, 16'd888);
    check("R6 response before next accept", rsp_cnt, rc + 1);
    check("R6 rsp data", int'(last_data), 70 * 3 + 7);
    idle(4);

    // R5 fence
    stall = 1'b1;
    for (int i = 0; i < 4; i++) send(3'd1, 8'(80 + i), 16'(600 + i));
    base = n_log;
    send(3'd2, 8'd0, 16'h0);
    probe(3'd0, 8'd90, 0, "R5 load held by fence");
    stall = 1'b0;
    send(3'd0, 8'd90, 16'h0);
    check("R5 drained before accept", n_log - base, 4);
    idle(6);
    send(3'd2, 8'd0, 16'h0);
    check("R5 empty fence free", int'(req_ready), 1);

    // R7 release store, R8 port stability
    stall = 1'b1;
    base = n_log;
    send(3'd1, 8'd100, 16'd1);
    send(3'd4, 8'd101, 16'd2);
    send(3'd1, 8'd102, 16'd3);
    send(3'd0, 8'd103, 16'h0);
    a0 = mem_addr;
    idle(2);
    check("R8 addr held", int'(mem_addr), int'(a0));
    check("R7 write shown while release queued", int'(mem_we), 1);
    stall = 1'b0;
    idle(10);
    check("R7 w100", int'(log_addr[base]), 100);
    check("R7 release second", int'(log_addr[base + 1]), 101);
    check("R7 read after release", int'(log_we[base + 2]), 0);
    check("R7 read addr", int'(log_addr[base + 2]), 103);
    check("R7 younger store last", int'(log_addr[base + 3]), 102);
    stall = 1'b1;
    send(3'd0, 8'd104, 16'h0);
    probe(3'd4, 8'd105, 0, "R7 release waits for load");
    stall = 1'b0;
    send(3'd4, 8'd105, 16'd9);
    idle(6);
    check("R7 release written", int'(mem[105]), 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule